// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block holds a 4 KiB window of 32-bit configuration words. A bus master reaches the window through a word-addressed port with separate read and write strobes. Only the storage and the access rules are modelled. The stored values drive nothing else in the chip.

Each word offset falls into one of four classes: read/write, read-only, write-only or unmapped. An access that its class does not allow raises a one-cycle error pulse and changes nothing. Ordinary read/write words are protected by a lock that comes up set at reset. The master clears it by writing a 16-bit key to an unlock word, and sets it again by writing a different key to a lock word. The one-bit scratch word at offset 0x000 stays writable at all times. An accepted write that sets bit 0 of the reset-control word produces a single-cycle soft-reset request.

Top module: `key_locked_ctrl_bank`

## Requirements
- R1: After reset, the bank reads back these values: 1 at 0x00C, 0x0001A008 at 0x100, 0x0000003F at 0x10C, 0x00014000 at 0x118, 0x00000040 at 0x250 and 0x00000001 at 0x25C. Port addresses are byte offsets divided by four.
- R2: A write to 0x008 whose low 16 bits equal 0xDF0D clears the lock, and 0x00C then reads 0. A write to 0x008 with any other low half leaves the lock unchanged. The upper 16 data bits are ignored.
- R3: A write to 0x004 whose low 16 bits equal 0x767B sets the lock, and 0x00C then reads 1. A write to 0x004 with any other low half leaves the lock unchanged.
- R4: While the lock is set, a write to a read/write word other than 0x000 is dropped without an error. Offset 0x000 accepts writes whatever the lock state, stores only bit 0 of the data, and reads 0 in bits 31:1.
- R5: The write-only offsets are 0x004, 0x008, 0x60C and 0x614. The read-only offsets are 0x00C, 0x10C, 0x17C, 0x18C, 0x19C, 0x1AC, 0x25C, 0x530, 0x618 and 0x620. A read of a write-only offset returns 0 and pulses the error output. A write to a read-only offset pulses the error output and leaves the word unchanged.
- R6: A read of an unmapped offset (for example 0x11C or 0xFFC) returns 0 and pulses the error output. A write to an unmapped offset pulses the error output and changes no mapped word.
- R7: An accepted write (lock clear) to 0x200 with bit 0 set drives the soft-reset request high for exactly the one cycle after the write edge. No request is made when bit 0 is clear or when the lock is set. The written value is stored in every accepted case.
- R8: Read data and the error pulse are registered. They become valid one clock after the strobe. Read data holds its last value while no read is made, and the error output is low in cycles without a violation.
- R9: Offset 0x00C reads the current lock state in bit 0 and zero in the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for all bank state |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| word_addr | input | 10 | Word index (byte offset divided by four) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| access_err | output | 1 | One-cycle pulse on an illegal access |
| soft_rst_req | output | 1 | One-cycle soft-reset request |

## Verification
The in-module assertions check on every cycle that:
- a correct key moves the lock to the right state;
- a locked write leaves its target word unchanged;
- every soft-reset pulse traces back to an accepted write with bit 0 set;
- class violations and unmapped reads produce the error pulse, and unmapped reads return zero.

Only the bench scenarios can show the rest:
- that the reset values are correct;
- that wrong keys and upper-half key bits are ignored;
- that the scratch word masks to one bit;
- that read data holds between reads;
- that no request appears for a cleared bit or while the bank is locked.

// File: rtl/key_locked_ctrl_bank.sv
module key_locked_ctrl_bank #(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] LOCK_KEY = 16'h767B,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] word_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          access_err,
  output logic          soft_rst_req
);

  localparam int NWORDS = 1 << AW;
  localparam logic [1:0] CLS_NONE = 2'd0, CLS_RW = 2'd1, CLS_RO = 2'd2, CLS_WO = 2'd3;
  localparam int IDX_SCRATCH = 'h000;
  localparam int IDX_LOCK    = 'h001;
  localparam int IDX_UNLOCK  = 'h002;
  localparam int IDX_LSTAT   = 'h003;
  localparam int IDX_RSTCTL  = 'h080;

  function automatic logic [1:0] word_class(input logic [AW-1:0] w);
    int unsigned v;
    v = int'(w);
    if (v inside {'h001, 'h002, 'h183, 'h185})
      return CLS_WO;
    if (v inside {'h003, 'h043, 'h05F, 'h063, 'h067, 'h06B, 'h097, 'h14C, 'h186, 'h188})
      return CLS_RO;
    if (v inside {'h000, ['h040:'h042], ['h044:'h046], ['h048:'h05B],
                  ['h05C:'h05E], ['h060:'h062], ['h064:'h066], ['h068:'h06A],
                  'h06E, 'h070, 'h071, ['h080:'h091], 'h093, 'h094, 'h096,
                  'h0C0, 'h0C1, ['h110:'h112], 'h180, 'h187, ['h1C0:'h1F5],
                  ['h201:'h203], 'h20C, 'h20D, 'h240, 'h244, 'h280, 'h28C,
                  'h294, ['h298:'h2A3], 'h2A4, 'h2A8, 'h2AC, ['h2C0:'h2C3],
                  'h2C5, 'h2C6, ['h2D0:'h2DD]})
      return CLS_RW;
    return CLS_NONE;
  endfunction

  function automatic logic [DW-1:0] reset_word(input int unsigned v);
    logic [31:0] r;
    r = 32'h0;
    if (v inside {['h040:'h042]})      r = 32'h0001A008;
    else if (v == 'h043)               r = 32'h0000003F;
    else if (v inside {['h044:'h046]}) r = 32'h00014000;
    else if (v == 'h048)               r = 32'h1F000400;
    else if (v == 'h049)               r = 32'h18400003;
    else if (v == 'h04A)               r = 32'h01E03201;
    else if (v == 'h04B)               r = 32'h01FFCCCD;
    else if (v inside {'h04C, 'h04D})  r = 32'h00101941;
    else if (v inside {'h04E, 'h04F})  r = 32'h00000001;
    else if (v inside {['h050:'h052]}) r = 32'h00003C01;
    else if (v == 'h053)               r = 32'h00002821;
    else if (v == 'h054)               r = 32'h00001E03;
    else if (v inside {'h055, 'h056})  r = 32'h00003F03;
    else if (v == 'h057)               r = 32'h00501903;
    else if (v == 'h059)               r = 32'h00000F03;
    else if (v == 'h05A)               r = 32'h00000F01;
    else if (v inside {'h05C, 'h060, 'h064, 'h068}) r = 32'h00101800;
    else if (v inside {'h05F, 'h063, 'h067, 'h06B}) r = 32'h00010000;
    else if (v == 'h06E)               r = 32'h0000001F;
    else if (v inside {'h070, 'h071})  r = 32'h00000001;
    else if (v == 'h090)               r = 32'h01F33F0F;
    else if (v == 'h094)               r = 32'h00000040;
    else if (v == 'h097)               r = 32'h00000001;
    else if (v inside {['h1C2:'h1C8]}) r = 32'h00000601;
    else if (v inside {['h1C0:'h1F5]}) r = 32'h00001601;
    else if (v inside {'h202, 'h203})  r = 32'hFFFFFFFF;
    else if (v == 'h280)               r = 32'h00010101;
    else if (v == 'h28C)               r = 32'h09090909;
    else if (v == 'h294)               r = 32'h00000009;
    else if (v inside {'h29A, 'h29D, 'h2A0, 'h2A3}) r = 32'h00000909;
    else if (v inside {['h298:'h2A3]}) r = 32'h09090909;
    else if (v == 'h2A4)               r = 32'h01010101;
    else if (v == 'h2A8)               r = 32'h00000909;
    else if (v == 'h2AC)               r = 32'h00000001;
    else if (v inside {['h2D0:'h2D6]}) r = 32'h00000E00;
    else if (v == 'h2DC)               r = 32'h00000021;
    return DW'(r);
  endfunction

  logic [DW-1:0] mem [NWORDS];
  logic          lock_q;
  logic [1:0]    cls;
  logic          wr_key_lock, wr_key_unlock, wr_store, rd_bad, wr_bad;

  assign cls           = word_class(word_addr);
  assign wr_key_lock   = wr_en && (int'(word_addr) == IDX_LOCK) && (wr_data[KEY_W-1:0] == LOCK_KEY);
  assign wr_key_unlock = wr_en && (int'(word_addr) == IDX_UNLOCK) && (wr_data[KEY_W-1:0] == UNLOCK_KEY);
  assign wr_store      = wr_en && (cls == CLS_RW) &&
                         (!lock_q || int'(word_addr) == IDX_SCRATCH);
  assign rd_bad        = rd_en && (cls == CLS_WO || cls == CLS_NONE);
  assign wr_bad        = wr_en && (cls == CLS_RO || cls == CLS_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lock_q <= 1'b1;
    else if (wr_key_lock)
      lock_q <= 1'b1;
    else if (wr_key_unlock)
      lock_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++)
        mem[i] <= reset_word(i);
    end else if (wr_store) begin
      if (int'(word_addr) == IDX_SCRATCH)
        mem[word_addr] <= DW'(wr_data[0]);
      else
        mem[word_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data      <= '0;
      access_err   <= 1'b0;
      soft_rst_req <= 1'b0;
    end else begin
      access_err   <= rd_bad || wr_bad;
      soft_rst_req <= wr_store && (int'(word_addr) == IDX_RSTCTL) && wr_data[0];
      if (rd_en) begin
        if (int'(word_addr) == IDX_LSTAT)
          rd_data <= DW'(lock_q);
        else if (cls == CLS_RW || cls == CLS_RO)
          rd_data <= mem[word_addr];
        else
          rd_data <= '0;
      end
    end
  end

  assert_lock_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_key_lock |=> lock_q);

  assert_unlock_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_key_unlock |=> !lock_q);

  assert_locked_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && cls == CLS_RW && int'(word_addr) != IDX_SCRATCH)
      |=> mem[$past(word_addr)] == $past(mem[word_addr]));

  assert_softrst_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |-> $past(wr_en && !lock_q && int'(word_addr) == IDX_RSTCTL && wr_data[0]));

  assert_class_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cls == CLS_RO) || (rd_en && cls == CLS_WO) |=> access_err);

  assert_unmapped_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cls == CLS_NONE) |=> (rd_data == '0 && access_err));

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |-> $past(rd_en || wr_en));

endmodule

// File: tb/key_locked_ctrl_bank_tb.sv
module key_locked_ctrl_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [9:0]  word_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        access_err, soft_rst_req;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  key_locked_ctrl_bank u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .word_addr(word_addr), .wr_data(wr_data), .rd_data(rd_data),
    .access_err(access_err), .soft_rst_req(soft_rst_req));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [11:0] boff, output logic [31:0] d, output logic e);
    @(negedge clk);
    word_addr = boff[11:2]; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; e = access_err;
  endtask

  task automatic do_write(input logic [11:0] boff, input logic [31:0] v, output logic e, output logic p);
    @(negedge clk);
    word_addr = boff[11:2]; wr_data = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    e = access_err; p = soft_rst_req;
  endtask

  task automatic read_expect(input string req, input logic [11:0] boff, input logic [31:0] exp, input logic exp_err);
    logic [31:0] d; logic e;
    do_read(boff, d, e);
    check(req, d, exp);
    check({req, " err"}, {31'b0, e}, {31'b0, exp_err});
  endtask

  task automatic write_expect(input string req, input logic [11:0] boff, input logic [31:0] v, input logic exp_err);
    logic e, p;
    do_write(boff, v, e, p);
    check({req, " err"}, {31'b0, e}, {31'b0, exp_err});
  endtask

  task automatic t_reset_values;
    read_expect("R1 lockstat", 12'h00C, 32'h1, 1'b0);
    read_expect("R1 pllctl", 12'h100, 32'h0001A008, 1'b0);
    read_expect("R1 pllsta", 12'h10C, 32'h0000003F, 1'b0);
    read_expect("R1 pllcfg", 12'h118, 32'h00014000, 1'b0);
    read_expect("R1 rstreason", 12'h250, 32'h00000040, 1'b0);
    read_expect("R1 bootmode", 12'h25C, 32'h00000001, 1'b0);
  endtask

  task automatic t_locked_and_scratch;
    write_expect("R4 locked wr", 12'h100, 32'h12345678, 1'b0);
    read_expect("R4 locked drop", 12'h100, 32'h0001A008, 1'b0);
    write_expect("R4 scratch wr", 12'h000, 32'hFFFFFFFF, 1'b0);
    read_expect("R4 scratch bit0", 12'h000, 32'h1, 1'b0);
    write_expect("R4 scratch wr0", 12'h000, 32'hFFFFFFFE, 1'b0);
    read_expect("R4 scratch clr", 12'h000, 32'h0, 1'b0);
  endtask

  task automatic t_unlock;
    write_expect("R2 bad key", 12'h008, 32'h0000DF0E, 1'b0);
    read_expect("R2 still locked", 12'h00C, 32'h1, 1'b0);
    write_expect("R2 good key", 12'h008, 32'hABCDDF0D, 1'b0);
    read_expect("R2 R9 unlocked", 12'h00C, 32'h0, 1'b0);
    write_expect("R4 unlocked wr", 12'h100, 32'h12345678, 1'b0);
    read_expect("R4 unlocked store", 12'h100, 32'h12345678, 1'b0);
  endtask

  task automatic t_class_rules;
    write_expect("R5 ro write", 12'h10C, 32'h0, 1'b1);
    read_expect("R5 ro kept", 12'h10C, 32'h0000003F, 1'b0);
    write_expect("R5 ro bootmode", 12'h25C, 32'h5, 1'b1);
    read_expect("R5 bootmode kept", 12'h25C, 32'h1, 1'b0);
    read_expect("R5 wo read cal", 12'h60C, 32'h0, 1'b1);
    read_expect("R5 wo read lock", 12'h004, 32'h0, 1'b1);
    write_expect("R5 wo write ok", 12'h614, 32'h1, 1'b0);
    write_expect("R6 unmapped wr", 12'h11C, 32'hDEADBEEF, 1'b1);
    read_expect("R6 unmapped rd", 12'h11C, 32'h0, 1'b1);
    read_expect("R6 neighbour", 12'h118, 32'h00014000, 1'b0);
    read_expect("R6 top unmapped", 12'hFFC, 32'h0, 1'b1);
  endtask

  task automatic t_soft_reset;
    logic e, p;
    do_write(12'h200, 32'h1, e, p);
    check("R7 pulse high", {31'b0, p}, 32'h1);
    @(negedge clk);
    check("R7 pulse one cycle", {31'b0, soft_rst_req}, 32'h0);
    read_expect("R7 stored", 12'h200, 32'h1, 1'b0);
    do_write(12'h200, 32'h2, e, p);
    check("R7 bit0 clear no pulse", {31'b0, p}, 32'h0);
    read_expect("R7 stored2", 12'h200, 32'h2, 1'b0);
    write_expect("R3 bad key", 12'h004, 32'h0000767A, 1'b0);
    read_expect("R3 stays unlocked", 12'h00C, 32'h0, 1'b0);
    write_expect("R3 good key", 12'h004, 32'hFFFF767B, 1'b0);
    read_expect("R3 R9 locked", 12'h00C, 32'h1, 1'b0);
    do_write(12'h200, 32'h1, e, p);
    check("R7 locked no pulse", {31'b0, p}, 32'h0);
    read_expect("R7 locked kept", 12'h200, 32'h2, 1'b0);
  endtask

  task automatic t_read_timing;
    read_expect("R8 read", 12'h104, 32'h0001A008, 1'b0);
    @(negedge clk);
    check("R8 hold data", rd_data, 32'h0001A008);
    check("R8 err idle", {31'b0, access_err}, 32'h0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1;
    check("R1 reset err", {31'b0, access_err}, 32'h0);
    check("R1 reset req", {31'b0, soft_rst_req}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_values();
    t_locked_and_scratch();
    t_unlock();
    t_class_rules();
    t_soft_reset();
    t_read_timing();
    finish_run();
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule